// File: doc/BRIEF.md
# Dual-Granularity Spare Remapper

This block keeps a small sparing table for a stacked memory and steers accesses away from regions reported faulty. Each fault report carries a bank, a row and a one-bit class. A small-class fault (a bit, word or row failure) is repaired by redirecting the whole affected row to a spare row. A large-class fault (a column or bank failure) is repaired by redirecting the whole bank to a spare bank. Both kinds of spare live on the ECC die. The output address has a die-select bit that is set whenever the access was redirected there.

Access lookup is a combinational compare against every table entry. The result is registered, so the remapped address appears one cycle after the access. The spare pools have a fixed size. A report that needs a spare when none of its class is free is dropped, and a sticky flag for that class is raised. When a bank takes a spare bank, the row spares already held inside that bank are given back to the row pool.

Top module: `spare_remap`

## Requirements
- R1: After reset, no spare is in use, both exhausted flags are 0 and `out_valid` is 0.
- R2: An access that matches no spare produces, one cycle later, `out_valid`=1 and `out_ecc`=0, with bank, row and column equal to the input.
- R3: A small fault report (`flt_large`=0) takes the lowest-numbered free row spare k. Later accesses to that bank and row give `out_ecc`=1, `out_bank`=N_BANK_SP and `out_row`=k.
- R4: A large fault report (`flt_large`=1) takes the lowest-numbered free bank spare j. Later accesses to any row of that bank give `out_ecc`=1 and `out_bank`=j, with the row unchanged.
- R5: Once a bank is spared, an access to it goes to the spare bank even if its row was spared before. The row and bank tables never both match one access.
- R6: Sparing a bank frees every row spare held in that bank, and the freed slots can be taken by later small faults.
- R7: A report for a location that is already covered takes no spare. This applies to a repeated row, to a small fault in a spared bank, and to a repeated bank.
- R8: A report that needs a spare when none of its class is free sets that class's sticky flag (`row_exhausted` or `bank_exhausted`) and changes no mapping.
- R9: An access presented in the same cycle as a report is mapped with the table as it stood before that report.
- R10: The column field always passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_valid | input | 1 | Fault report strobe |
| flt_large | input | 1 | Fault class: 0 small (row spare), 1 large (bank spare) |
| flt_bank | input | BANK_W | Faulty bank |
| flt_row | input | ROW_W | Faulty row (used for small faults) |
| acc_valid | input | 1 | Access strobe |
| acc_bank | input | BANK_W | Access bank |
| acc_row | input | ROW_W | Access row |
| acc_col | input | COL_W | Access column |
| out_valid | output | 1 | Remapped address valid, one cycle after the access |
| out_ecc | output | 1 | 1 when the address points into the ECC-die spare area |
| out_bank | output | BANK_W | Physical bank |
| out_row | output | ROW_W | Physical row |
| out_col | output | COL_W | Physical column |
| row_exhausted | output | 1 | Sticky: a small fault found no free row spare |
| bank_exhausted | output | 1 | Sticky: a large fault found no free bank spare |

## Verification
A fault report and an access can arrive in the same clock cycle, and the access may target the location being reported. The bench provokes this by issuing a bank-sparing report for a bank whose row is already row-spared, together with an access to that row. The access must come back through the old row spare, and only the next access to that row moves to the new spare bank. A behavioural table model in the bench applies the lookup before the update on every clock and judges every cycle, including randomly mixed traffic.

// File: rtl/spare_remap.sv
module spare_remap #(
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 6,
  parameter int COL_W     = 4,
  parameter int N_ROW_SP  = 4,
  parameter int N_BANK_SP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic              flt_large,
  input  logic [BANK_W-1:0] flt_bank,
  input  logic [ROW_W-1:0]  flt_row,
  input  logic              acc_valid,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [COL_W-1:0]  acc_col,
  output logic              out_valid,
  output logic              out_ecc,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic              row_exhausted,
  output logic              bank_exhausted
);
  localparam int RI_W = (N_ROW_SP  > 1) ? $clog2(N_ROW_SP)  : 1;
  localparam int BI_W = (N_BANK_SP > 1) ? $clog2(N_BANK_SP) : 1;
  localparam logic [BANK_W-1:0] ROW_REGION = BANK_W'(N_BANK_SP);

  logic [N_ROW_SP-1:0]  rv;
  logic [BANK_W-1:0]    rb [N_ROW_SP];
  logic [ROW_W-1:0]     rr [N_ROW_SP];
  logic [N_BANK_SP-1:0] bv;
  logic [BANK_W-1:0]    bb [N_BANK_SP];

  logic [N_ROW_SP-1:0]  row_hit, f_row_dup, f_row_inbank;
  logic [N_BANK_SP-1:0] bank_hit, f_bank_dup;

  for (genvar i = 0; i < N_ROW_SP; i++) begin : g_row
    assign row_hit[i]      = rv[i] && rb[i] == acc_bank && rr[i] == acc_row;
    assign f_row_dup[i]    = rv[i] && rb[i] == flt_bank && rr[i] == flt_row;
    assign f_row_inbank[i] = rv[i] && rb[i] == flt_bank;
  end
  for (genvar j = 0; j < N_BANK_SP; j++) begin : g_bank
    assign bank_hit[j]   = bv[j] && bb[j] == acc_bank;
    assign f_bank_dup[j] = bv[j] && bb[j] == flt_bank;
  end

  logic [RI_W-1:0] row_idx, rfree;
  logic [BI_W-1:0] bank_idx, bfree;
  always_comb begin
    row_idx = '0;
    rfree   = '0;
    for (int i = N_ROW_SP - 1; i >= 0; i--) begin
      if (row_hit[i]) row_idx = RI_W'(i);
      if (!rv[i])     rfree   = RI_W'(i);
    end
    bank_idx = '0;
    bfree    = '0;
    for (int j = N_BANK_SP - 1; j >= 0; j--) begin
      if (bank_hit[j]) bank_idx = BI_W'(j);
      if (!bv[j])      bfree    = BI_W'(j);
    end
  end

  wire small_req  = flt_valid && !flt_large && !(|f_bank_dup) && !(|f_row_dup);
  wire large_req  = flt_valid &&  flt_large && !(|f_bank_dup);
  wire row_alloc  = small_req && !(&rv);
  wire bank_alloc = large_req && !(&bv);

  always_ff @(posedge clk) begin
    if (rst) begin
      rv <= '0;
      bv <= '0;
      row_exhausted  <= 1'b0;
      bank_exhausted <= 1'b0;
    end else begin
      if (bank_alloc) begin
        bv[bfree] <= 1'b1;
        bb[bfree] <= flt_bank;
        rv <= rv & ~f_row_inbank;
      end
      if (row_alloc) begin
        rv[rfree] <= 1'b1;
        rb[rfree] <= flt_bank;
        rr[rfree] <= flt_row;
      end
      if (small_req && (&rv)) row_exhausted  <= 1'b1;
      if (large_req && (&bv)) bank_exhausted <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ecc   <= 1'b0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= acc_valid;
      out_col   <= acc_col;
      if (|bank_hit) begin
        out_ecc  <= 1'b1;
        out_bank <= BANK_W'(bank_idx);
        out_row  <= acc_row;
      end else if (|row_hit) begin
        out_ecc  <= 1'b1;
        out_bank <= ROW_REGION;
        out_row  <= ROW_W'(row_idx);
      end else begin
        out_ecc  <= 1'b0;
        out_bank <= acc_bank;
        out_row  <= acc_row;
      end
    end
  end

  // R2 latency
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  // R7 no duplicate row tags
  a_r7_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_hit));
  a_r7_bank_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_hit));
  // R5 never both tables for one access
  a_r5_no_dual_hit: assert property (@(posedge clk) disable iff (rst)
    !((|row_hit) && (|bank_hit)));
  // R8 sticky and caused by a report
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    row_exhausted |=> row_exhausted);
  a_r8_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(bank_exhausted) |-> $past(flt_valid && flt_large));
  // R10 column passthrough
  a_r10_col: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_col == $past(acc_col));
endmodule

// File: tb/sim_spare_remap.sv
module sim_spare_remap;
  localparam int BW = 3, RW = 6, CW = 4, NR = 4, NB = 2;
  logic clk = 0, rst = 1;
  logic flt_valid = 0, flt_large = 0, acc_valid = 0;
  logic [BW-1:0] flt_bank = 0, acc_bank = 0;
  logic [RW-1:0] flt_row = 0, acc_row = 0;
  logic [CW-1:0] acc_col = 0;
  logic out_valid, out_ecc, row_exhausted, bank_exhausted;
  logic [BW-1:0] out_bank;
  logic [RW-1:0] out_row;
  logic [CW-1:0] out_col;

  spare_remap #(.BANK_W(BW), .ROW_W(RW), .COL_W(CW), .N_ROW_SP(NR), .N_BANK_SP(NB)) u0 (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_large(flt_large),
    .flt_bank(flt_bank), .flt_row(flt_row), .acc_valid(acc_valid),
    .acc_bank(acc_bank), .acc_row(acc_row), .acc_col(acc_col),
    .out_valid(out_valid), .out_ecc(out_ecc), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col),
    .row_exhausted(row_exhausted), .bank_exhausted(bank_exhausted));

  always #5 clk = ~clk;

  int vectors = 0, fails = 0;
  string tag = "R1";
  int rs [NR];
  int bs [NB];
  int ev, ee, eb, er, ec, erx, ebx;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) rs[i] = -1;
      for (int j = 0; j < NB; j++) bs[j] = -1;
      ev = 0; ee = 0; eb = 0; er = 0; ec = 0; erx = 0; ebx = 0;
    end else begin
      int hb, hr, fb, fr;
      bit covered;
      hb = -1; hr = -1;
      for (int j = 0; j < NB; j++) if (bs[j] == int'(acc_bank)) hb = j;
      for (int i = 0; i < NR; i++) if (rs[i] == int'(acc_bank) * 1024 + int'(acc_row)) hr = i;
      ev = acc_valid; ec = acc_col;
      if (hb >= 0) begin ee = 1; eb = hb; er = acc_row; end
      else if (hr >= 0) begin ee = 1; eb = NB; er = hr; end
      else begin ee = 0; eb = acc_bank; er = acc_row; end
      if (flt_valid) begin
        covered = 0;
        for (int j = 0; j < NB; j++) if (bs[j] == int'(flt_bank)) covered = 1;
        if (flt_large && !covered) begin
          fb = -1;
          for (int j = NB - 1; j >= 0; j--) if (bs[j] < 0) fb = j;
          if (fb < 0) ebx = 1;
          else begin
            bs[fb] = flt_bank;
            for (int i = 0; i < NR; i++) if (rs[i] >= 0 && rs[i] / 1024 == int'(flt_bank)) rs[i] = -1;
          end
        end else if (!flt_large && !covered) begin
          for (int i = 0; i < NR; i++) if (rs[i] == int'(flt_bank) * 1024 + int'(flt_row)) covered = 1;
          if (!covered) begin
            fr = -1;
            for (int i = NR - 1; i >= 0; i--) if (rs[i] < 0) fr = i;
            if (fr < 0) erx = 1;
            else rs[fr] = int'(flt_bank) * 1024 + int'(flt_row);
          end
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'(ev) || (ev && (out_ecc !== 1'(ee) || out_bank !== BW'(eb) ||
        out_row !== RW'(er) || out_col !== CW'(ec))) ||
        row_exhausted !== 1'(erx) || bank_exhausted !== 1'(ebx))
    begin
      fails++;
      $display("FAIL %s: got v%0d e%0d b%0d r%0d c%0d x%0d%0d, expected v%0d e%0d b%0d r%0d c%0d x%0d%0d",
        tag, out_valid, out_ecc, out_bank, out_row, out_col, row_exhausted, bank_exhausted,
        ev, ee, eb, er, ec, erx, ebx);
    end
  endtask

  task automatic acc(input int b, input int r, input int c);
    acc_valid = 1; acc_bank = BW'(b); acc_row = RW'(r); acc_col = CW'(c);
  endtask
  task automatic flt(input bit lg, input int b, input int r);
    flt_valid = 1; flt_large = lg; flt_bank = BW'(b); flt_row = RW'(r);
  endtask
  task automatic idle();
    acc_valid = 0; flt_valid = 0;
  endtask
  task automatic rep(input bit lg, input int b, input int r);
    flt(lg, b, r); tick(); idle();
  endtask
  task automatic look(input int b, input int r, input int c);
    acc(b, r, c); tick(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1"; tick(); tick();
    tag = "R2"; look(0, 5, 1); look(7, 63, 15);
    tag = "R3"; rep(0, 1, 5); look(1, 5, 3); look(1, 6, 2);
    tag = "R7"; rep(0, 1, 5); look(1, 5, 4);
    tag = "R3"; rep(0, 2, 1); rep(0, 3, 7); rep(0, 1, 9); look(3, 7, 0); look(1, 9, 9);
    tag = "R8"; rep(0, 4, 0); look(4, 0, 6); tick();
    tag = "R4"; rep(1, 1, 0); look(1, 33, 5);
    tag = "R5"; look(1, 5, 7); look(1, 9, 1);
    tag = "R6"; rep(0, 5, 2); look(5, 2, 8); rep(0, 6, 3); look(6, 3, 2);
    tag = "R7"; rep(0, 1, 20); look(1, 20, 0); rep(1, 1, 0); look(1, 0, 0);
    tag = "R9"; flt(1, 2, 0); acc(2, 1, 11); tick(); idle(); look(2, 1, 11);
    tag = "R8"; rep(1, 6, 0); look(6, 3, 3); look(7, 2, 2);
    tag = "R10";
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(3) == 0) begin
        rst = ($urandom_range(40) == 0);
        flt($urandom_range(1), $urandom_range(7), $urandom_range(7));
      end
      if ($urandom_range(1)) acc($urandom_range(7), $urandom_range(7), $urandom_range(15));
      tick(); idle(); rst = 0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule